// File: doc/BRIEF.md
# Standby Mode Clock Controller

This controller handles the two low-power standby depths of a small processor core. A light standby request stops only the core clock and leaves every oscillator running, so an interrupt can bring the core back on the next cycle. A deep standby request also shuts down the main crystal oscillator. On wake-up from deep standby, the core clock stays gated until the restarted source is usable. That is a programmable number of reference ticks for the crystal, or a fixed hold of core cycles for the internal ring oscillator.

Whether deep standby is allowed depends on which source currently drives the core. A deep request made while the core runs on the subsystem (low-speed) clock is refused, and a sticky flag records the refusal until software clears it. The block drives only clock enables and status. The oscillators themselves, state retention and interrupt arbitration are handled elsewhere.

Top module: `pwr_standby_ctl`

## Requirements
- R1: After reset the mode is RUN (`mode_o` = 0), the core clock enable and all three oscillator enables are 1, and `bad_stop_o` is 0.
- R2: In RUN with no interrupt, a light request (`halt_req_i`) moves the mode to LIGHT (`mode_o` = 1) at the next clock edge. In LIGHT the core clock enable is 0 and all three oscillator enables stay 1.
- R3: In RUN with no interrupt, a deep request (`stop_req_i`) with source 0 (crystal) or 1 (ring) moves the mode to DEEP (`mode_o` = 2) at the next edge. In DEEP the core clock enable and the crystal enable are 0, and the ring and subsystem enables are 1.
- R4: An interrupt (`irq_i`) seen in LIGHT returns the mode to RUN at the next edge, and the core clock enable is 1 from that edge on.
- R5: An interrupt seen in DEEP with the crystal as the latched source moves the mode to SETTLE (`mode_o` = 3), where the crystal enable is 1 and the core clock enable is 0. The mode returns to RUN at the edge of the N-th `ref_tick_i` pulse after that. N is `stab_cnt_i` as sampled on deep entry, and a sampled 0 counts as 1.
- R6: An interrupt seen in DEEP with the ring oscillator as the latched source gives exactly 17 cycles in SETTLE before RUN, whatever `ref_tick_i` does.
- R7: A deep request in RUN with source 2 (subsystem) is ignored and sets `bad_stop_o`. The flag holds until `flag_clr_i` is pulsed, and a new refusal in the same cycle as a clear takes precedence over the clear.
- R8: An interrupt in the same cycle as a light or deep request keeps the mode in RUN.
- R9: The ring oscillator enable is 1 in every mode.
- R10: Source code 3 behaves as the crystal: deep entry is accepted and wake-up uses the tick-counted wait.
- R11: When a legal deep request and a light request arrive together, deep standby is entered. When a refused deep request arrives with a light request, light standby is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| halt_req_i | input | 1 | Light standby request |
| stop_req_i | input | 1 | Deep standby request |
| irq_i | input | 1 | Wake-up interrupt request |
| clk_src_i | input | 2 | Core clock source: 0 crystal, 1 ring, 2 subsystem, 3 crystal |
| stab_cnt_i | input | 16 | Crystal settle length in reference ticks |
| ref_tick_i | input | 1 | Reference tick strobe for the crystal settle count |
| flag_clr_i | input | 1 | Clears the refused-request flag |
| cpu_clk_en_o | output | 1 | Core clock enable |
| x1_osc_en_o | output | 1 | Crystal oscillator enable |
| ring_osc_en_o | output | 1 | Ring oscillator enable |
| sub_osc_en_o | output | 1 | Subsystem oscillator enable |
| mode_o | output | 2 | Mode: 0 RUN, 1 LIGHT, 2 DEEP, 3 SETTLE |
| bad_stop_o | output | 1 | Sticky refused deep request flag |

## Verification
The mode register is the only stage between a request or interrupt and the outputs. Every entry, every light-standby exit and every flag change is therefore visible one edge after the input is sampled. The bench drives on the falling edge and checks on the next falling edge. Crystal wake-up is checked tick by tick: after each tick the mode must still be SETTLE, except after the N-th tick, where it must be RUN. Ring wake-up is checked by counting the falling edges that see SETTLE, which must total 17. The settle count input is changed after deep entry to show that the sampled value is the one used.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [1:0] {
      MD_RUN    = 2'd0,
      MD_LIGHT  = 2'd1,
      MD_DEEP   = 2'd2,
      MD_SETTLE = 2'd3
   } stby_mode_e;

   localparam logic [1:0] SRC_XTAL = 2'd0;
   localparam logic [1:0] SRC_RING = 2'd1;
   localparam logic [1:0] SRC_SUB  = 2'd2;

   localparam int unsigned N_OSC   = 3;
   localparam int unsigned OSC_X1  = 0;
   localparam int unsigned OSC_RNG = 1;
   localparam int unsigned OSC_SUB = 2;

endpackage

// File: rtl/stby_fsm.sv
module stby_fsm
   import stby_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       halt_req_i,
   input  logic       stop_req_i,
   input  logic       irq_i,
   input  logic [1:0] clk_src_i,
   input  logic       flag_clr_i,
   input  logic       settle_done_i,
   output stby_mode_e mode_o,
   output logic       enter_deep_o,
   output logic       start_settle_o,
   output logic       ring_sel_o,
   output logic       bad_stop_o
);

   stby_mode_e mode_q, mode_d;
   logic       ring_q;
   logic       bad_q;
   logic       deep_ok;
   logic       refuse;

   // subsystem source cannot enter deep standby; code 3 falls to crystal
   assign deep_ok = (clk_src_i != SRC_SUB);
   assign refuse  = (mode_q == MD_RUN) && stop_req_i && !deep_ok;

   always_comb begin
      mode_d         = mode_q;
      enter_deep_o   = 1'b0;
      start_settle_o = 1'b0;
      unique case (mode_q)
         MD_RUN: begin
            if (!irq_i) begin
               if (stop_req_i && deep_ok) begin
                  mode_d       = MD_DEEP;
                  enter_deep_o = 1'b1;
               end else if (halt_req_i) begin
                  mode_d = MD_LIGHT;
               end
            end
         end
         MD_LIGHT: begin
            if (irq_i) mode_d = MD_RUN;
         end
         MD_DEEP: begin
            if (irq_i) begin
               mode_d         = MD_SETTLE;
               start_settle_o = 1'b1;
            end
         end
         MD_SETTLE: begin
            if (settle_done_i) mode_d = MD_RUN;
         end
         default: mode_d = MD_RUN;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mode_q <= MD_RUN;
         ring_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (enter_deep_o) ring_q <= (clk_src_i == SRC_RING);
         if (refuse)          bad_q <= 1'b1;
         else if (flag_clr_i) bad_q <= 1'b0;
      end
   end

   assign mode_o     = mode_q;
   assign ring_sel_o = ring_q;
   assign bad_stop_o = bad_q;

endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
   parameter int unsigned STAB_W    = 16,
   parameter int unsigned RING_HOLD = 17
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              capture_i,
   input  logic              start_i,
   input  logic              in_settle_i,
   input  logic              ring_sel_i,
   input  logic              ref_tick_i,
   input  logic [STAB_W-1:0] stab_cnt_i,
   output logic              done_o
);

   localparam int unsigned HOLD_W = $clog2(RING_HOLD + 1);
   localparam int unsigned CNT_W  = (STAB_W > HOLD_W) ? STAB_W : HOLD_W;
   localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(RING_HOLD);
   localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

   logic [STAB_W-1:0] stab_q;
   logic [CNT_W-1:0]  stab_ext;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  load_v;
   logic              step;

   generate
      if (CNT_W > STAB_W) begin : g_widen
         assign stab_ext = {{(CNT_W - STAB_W){1'b0}}, stab_q};
      end else begin : g_same
         assign stab_ext = stab_q;
      end
   endgenerate

   // zero in the sampled count still means one tick
   assign load_v = ring_sel_i ? HOLD_V
                 : ((stab_ext == '0) ? ONE_V : stab_ext);
   assign step   = in_settle_i && (ring_sel_i || ref_tick_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         stab_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (capture_i) stab_q <= stab_cnt_i;
         if (start_i)
            cnt_q <= load_v;
         else if (step && cnt_q != '0)
            cnt_q <= cnt_q - ONE_V;
      end
   end

   assign done_o = step && (cnt_q == ONE_V);

endmodule

// File: rtl/stby_osc_gate.sv
module stby_osc_gate
   import stby_pkg::*;
#(
   parameter logic [N_OSC-1:0] DEEP_OFF_MASK = 3'b001
) (
   input  stby_mode_e       mode_i,
   output logic             cpu_clk_en_o,
   output logic [N_OSC-1:0] osc_en_o
);

   logic in_deep;
   assign in_deep      = (mode_i == MD_DEEP);
   assign cpu_clk_en_o = (mode_i == MD_RUN);

   generate
      for (genvar g = 0; g < N_OSC; g++) begin : g_osc
         if (DEEP_OFF_MASK[g]) begin : g_gated
            assign osc_en_o[g] = !in_deep;
         end else begin : g_free
            assign osc_en_o[g] = 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/pwr_standby_ctl.sv
module pwr_standby_ctl
   import stby_pkg::*;
#(
   parameter int unsigned STAB_W    = 16,
   parameter int unsigned RING_HOLD = 17
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              halt_req_i,
   input  logic              stop_req_i,
   input  logic              irq_i,
   input  logic [1:0]        clk_src_i,
   input  logic [STAB_W-1:0] stab_cnt_i,
   input  logic              ref_tick_i,
   input  logic              flag_clr_i,
   output logic              cpu_clk_en_o,
   output logic              x1_osc_en_o,
   output logic              ring_osc_en_o,
   output logic              sub_osc_en_o,
   output logic [1:0]        mode_o,
   output logic              bad_stop_o
);

   // only the crystal is shut down in deep standby
   localparam logic [N_OSC-1:0] DEEP_OFF = N_OSC'(1) << OSC_X1;

   initial begin
      if (STAB_W < 1)    $error("STAB_W must be at least 1");
      if (RING_HOLD < 1) $error("RING_HOLD must be at least 1");
   end

   stby_mode_e       mode;
   logic             enter_deep;
   logic             start_settle;
   logic             ring_sel;
   logic             settle_done;
   logic [N_OSC-1:0] osc_en;

   stby_fsm u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .halt_req_i     (halt_req_i),
      .stop_req_i     (stop_req_i),
      .irq_i          (irq_i),
      .clk_src_i      (clk_src_i),
      .flag_clr_i     (flag_clr_i),
      .settle_done_i  (settle_done),
      .mode_o         (mode),
      .enter_deep_o   (enter_deep),
      .start_settle_o (start_settle),
      .ring_sel_o     (ring_sel),
      .bad_stop_o     (bad_stop_o)
   );

   stby_settle_timer #(
      .STAB_W    (STAB_W),
      .RING_HOLD (RING_HOLD)
   ) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .capture_i   (enter_deep),
      .start_i     (start_settle),
      .in_settle_i (mode == MD_SETTLE),
      .ring_sel_i  (ring_sel),
      .ref_tick_i  (ref_tick_i),
      .stab_cnt_i  (stab_cnt_i),
      .done_o      (settle_done)
   );

   stby_osc_gate #(
      .DEEP_OFF_MASK (DEEP_OFF)
   ) u_gate (
      .mode_i       (mode),
      .cpu_clk_en_o (cpu_clk_en_o),
      .osc_en_o     (osc_en)
   );

   assign x1_osc_en_o   = osc_en[OSC_X1];
   assign ring_osc_en_o = osc_en[OSC_RNG];
   assign sub_osc_en_o  = osc_en[OSC_SUB];
   assign mode_o        = mode;

endmodule

// File: rtl/stby_chk.sv
module stby_chk #(
   parameter int unsigned RING_HOLD = 17
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       halt_req_i,
   input logic       stop_req_i,
   input logic       irq_i,
   input logic [1:0] clk_src_i,
   input logic       flag_clr_i,
   input logic       cpu_clk_en_o,
   input logic       x1_osc_en_o,
   input logic       ring_osc_en_o,
   input logic       sub_osc_en_o,
   input logic [1:0] mode_o,
   input logic       bad_stop_o
);

   logic [31:0] settle_len;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)              settle_len <= '0;
      else if (mode_o == 2'd3)  settle_len <= settle_len + 32'd1;
      else                      settle_len <= '0;
   end

   // R2
   light_gating_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd1) |-> (!cpu_clk_en_o && x1_osc_en_o && sub_osc_en_o));

   // R3
   deep_gating_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd2) |-> (!cpu_clk_en_o && !x1_osc_en_o && sub_osc_en_o));

   // R4
   light_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd1 && irq_i) |=> cpu_clk_en_o);

   // R7
   refuse_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd0 && stop_req_i && clk_src_i == 2'd2) |=> bad_stop_o);

   // R8
   coincident_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd0 && irq_i && (halt_req_i || stop_req_i)) |=> (mode_o == 2'd0));

   // R9
   ring_always_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ring_osc_en_o);

   // R5
   settle_x1_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd3) |-> (x1_osc_en_o && !cpu_clk_en_o));

   // R7
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bad_stop_o && !flag_clr_i) |=> bad_stop_o);

endmodule

bind pwr_standby_ctl stby_chk #(.RING_HOLD(RING_HOLD)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .halt_req_i    (halt_req_i),
   .stop_req_i    (stop_req_i),
   .irq_i         (irq_i),
   .clk_src_i     (clk_src_i),
   .flag_clr_i    (flag_clr_i),
   .cpu_clk_en_o  (cpu_clk_en_o),
   .x1_osc_en_o   (x1_osc_en_o),
   .ring_osc_en_o (ring_osc_en_o),
   .sub_osc_en_o  (sub_osc_en_o),
   .mode_o        (mode_o),
   .bad_stop_o    (bad_stop_o)
);

// File: tb/pwr_standby_ctl_tb.sv
module pwr_standby_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halt_req = 1'b0, stop_req = 1'b0, irq = 1'b0;
   logic [1:0]  src = 2'd0;
   logic [15:0] stab = 16'd0;
   logic        tick = 1'b0, clr = 1'b0;
   logic        cpu_en, x1_en, ring_en, sub_en, bad;
   logic [1:0]  mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_standby_ctl u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .halt_req_i    (halt_req),
      .stop_req_i    (stop_req),
      .irq_i         (irq),
      .clk_src_i     (src),
      .stab_cnt_i    (stab),
      .ref_tick_i    (tick),
      .flag_clr_i    (clr),
      .cpu_clk_en_o  (cpu_en),
      .x1_osc_en_o   (x1_en),
      .ring_osc_en_o (ring_en),
      .sub_osc_en_o  (sub_en),
      .mode_o        (mode),
      .bad_stop_o    (bad)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // packs {mode, cpu, x1, ring, sub}
   function automatic int outs();
      return {mode, cpu_en, x1_en, ring_en, sub_en};
   endfunction

   task automatic go_deep(input logic [1:0] s, input logic [15:0] n);
      src = s; stab = n; stop_req = 1'b1;
      step();
      stop_req = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 outputs after reset", outs(), {2'd0, 4'b1111});
      check("R1 flag after reset", bad, 0);
      check("R9 ring on in RUN", ring_en, 1);
   endtask

   task automatic t_light();
      src = 2'd2; halt_req = 1'b1;
      step();
      halt_req = 1'b0;
      check("R2 light entry", outs(), {2'd1, 4'b0111});
      step();
      check("R2 light holds", mode, 1);
      irq = 1'b1;
      step();
      irq = 1'b0;
      check("R4 light exit immediate", outs(), {2'd0, 4'b1111});
   endtask

   task automatic t_deep_x1(input logic [1:0] s, input logic [15:0] n, input string tag);
      int expn;
      expn = (n == 0) ? 1 : n;
      go_deep(s, n);
      check({tag, " deep entry gating"}, outs(), {2'd2, 4'b0011});
      stab = 16'd40;   // must not affect the sampled count
      step();
      check({tag, " deep holds"}, mode, 2);
      irq = 1'b1;
      step();
      irq = 1'b0;
      check({tag, " settle x1 on, cpu off"}, outs(), {2'd3, 4'b0111});
      for (int k = 1; k <= expn; k++) begin
         tick = 1'b0;
         step();
         check({tag, " no tick keeps settle"}, mode, 3);
         tick = 1'b1;
         step();
         tick = 1'b0;
         if (k < expn) check({tag, " settle before last tick"}, mode, 3);
         else          check({tag, " run after last tick"}, outs(), {2'd0, 4'b1111});
      end
   endtask

   task automatic t_deep_ring();
      int cnt = 0;
      go_deep(2'd1, 16'd3);
      check("R3 ring-source deep entry", outs(), {2'd2, 4'b0011});
      irq = 1'b1;
      step();
      irq = 1'b0;
      tick = 1'b1;     // ticks must not shorten the ring hold
      for (int k = 0; k < 40; k++) begin
         if (mode == 2'd3) cnt++;
         else break;
         step();
      end
      tick = 1'b0;
      check("R6 ring settle length", cnt, 17);
      check("R6 run after ring settle", cpu_en, 1);
   endtask

   task automatic t_refuse();
      src = 2'd2; stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      check("R7 sub deep refused", outs(), {2'd0, 4'b1111});
      check("R7 flag set", bad, 1);
      step(); step();
      check("R7 flag sticky", bad, 1);
      clr = 1'b1; stop_req = 1'b1;
      step();
      stop_req = 1'b0;
      check("R7 set beats clear", bad, 1);
      step();
      clr = 1'b0;
      check("R7 flag cleared", bad, 0);
   endtask

   task automatic t_coincident();
      src = 2'd0; irq = 1'b1; halt_req = 1'b1;
      step();
      check("R8 irq blocks light", mode, 0);
      halt_req = 1'b0; stop_req = 1'b1;
      step();
      irq = 1'b0; stop_req = 1'b0;
      check("R8 irq blocks deep", mode, 0);
   endtask

   task automatic t_priority();
      src = 2'd0; halt_req = 1'b1; stop_req = 1'b1;
      step();
      halt_req = 1'b0; stop_req = 1'b0;
      check("R11 deep wins over light", mode, 2);
      irq = 1'b1;
      step();
      irq = 1'b0;
      tick = 1'b1;
      for (int k = 0; k < 20 && mode != 2'd0; k++) step();
      tick = 1'b0;
      src = 2'd2; halt_req = 1'b1; stop_req = 1'b1;
      step();
      halt_req = 1'b0; stop_req = 1'b0;
      check("R11 refused deep yields light", mode, 1);
      irq = 1'b1;
      step();
      irq = 1'b0;
      clr = 1'b1;
      step();
      clr = 1'b0;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_light();
      t_deep_x1(2'd0, 16'd3, "R5");
      t_deep_x1(2'd0, 16'd0, "R5 zero count");
      t_deep_x1(2'd3, 16'd2, "R10");
      t_deep_ring();
      t_refuse();
      t_coincident();
      t_priority();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule